// File: doc/BRIEF.md
# Near-Cache Atomic Read-Modify-Write Unit

This block sits next to the data array of a shared cache and carries out atomic operations on words held there. A core sends a request with an opcode, its requester tag, a word address and a 32-bit operand. The unit changes the word in place, so the requesting core never has to gain exclusive ownership of the line. It returns the value the word held before the change, which gives fetch-add and swap semantics. A plain word-addressed register array stands in for the cache data. The block does not handle misses, coherence or ordering against other addresses.

Requests pass in order through one three-stage pipeline: read, compute, write. When a request reads a word that an older request is still computing or writing, the newer value is forwarded to it, so back-to-back operations on one word never lose an update. Responses enter a small queue and leave under a valid/ready handshake. The unit takes one request per cycle as long as the queue has room for every request already in flight.

Top module: `near_atomic_alu`

## Requirements
- R1: After reset, rspValid is 0, reqReady is 1 and every storage word reads as 0.
- R2: Opcode 0 (fetch-add) returns the word's prior value and stores the prior value plus the operand.
- R3: Opcode 1 (exchange) returns the word's prior value and stores the operand.
- R4: Opcode 2 (read) returns the word's value and leaves it unchanged. Opcode 3 behaves exactly like opcode 2.
- R5: Each response carries the requester tag of its request, and responses leave in the order their requests were accepted.
- R6: Requests to the same word on consecutive cycles each see the result of every older request, so no update is lost.
- R7: With the pipeline and queue empty, the response to a request accepted at clock edge N becomes valid right after edge N+3.
- R8: reqReady is 0 whenever queued responses plus in-flight requests equal the queue depth. While rspReady is 0, a valid response holds its tag and data unchanged.
- R9: Addition wraps modulo 2^32 and raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request this cycle |
| reqOp | input | 2 | Operation: 0 fetch-add, 1 exchange, 2 read, 3 read |
| reqId | input | ID_W | Requester tag |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Operand |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Requester takes the response |
| rspId | output | ID_W | Requester tag echoed from the request |
| rspData | output | DATA_W | Prior value of the word |

## Verification
The hardest case to reach from the ports is a run of requests to one word that sit in the read, compute and write stages at once. Only then do both forwarding paths act in the same cycle. The random stimulus draws most addresses from a window of four words and keeps the response side ready most of the time, so the pipeline stays full. A directed burst of back-to-back fetch-adds to one word adds a guaranteed case. A second directed case holds rspReady low until the queue fills, which forces reqReady to drop while responses wait.

// File: rtl/natomic_pkg.sv
package natomic_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XCHG = 2'd1,
    OP_READ = 2'd2,
    OP_RSVD = 2'd3
  } atomOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load read-stage registers from request ports
    logic adv2;      // move read stage into compute stage
    logic adv3;      // move compute stage into write stage
    logic fwdEx;     // take old value from compute stage result
    logic fwdWr;     // take old value from write stage result
    logic memWrite;  // commit write-stage result to storage
    logic push;      // enqueue write-stage response
    logic pop;       // dequeue head response
  } strobes_t;

endpackage

// File: rtl/natomic_store.sv
module natomic_store #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (wrEn) begin
      words[wrAddr] <= wrData;
    end
  end

  assign rdData = words[rdAddr];

  // a committed result is visible at its address on the following cycle (R2, R3)
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> words[$past(wrAddr)] == $past(wrData));

endmodule

// File: rtl/natomic_ctrl.sv
module natomic_ctrl
  import natomic_pkg::*;
#(
  parameter int QDEPTH = 8,
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CNT_W = $clog2(QDEPTH + 1) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             rspReady,
  output logic             rspValid,
  input  logic             wrIsWrite,
  input  logic             matchS1Ex,
  input  logic             matchS1Wr,
  output strobes_t         stb,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr
);

  logic s1Valid, s2Valid, s3Valid;
  logic [CNT_W-1:0] qCount;
  logic [CNT_W-1:0] inFlight;

  assign inFlight = CNT_W'(s1Valid) + CNT_W'(s2Valid) + CNT_W'(s3Valid);
  assign reqReady = (qCount + inFlight) < CNT_W'(QDEPTH);
  assign rspValid = (qCount != '0);

  always_comb begin
    stb          = '0;
    stb.capture  = reqValid && reqReady;
    stb.adv2     = s1Valid;
    stb.adv3     = s2Valid;
    stb.fwdEx    = s1Valid && s2Valid && matchS1Ex;
    stb.fwdWr    = s1Valid && s3Valid && matchS1Wr;
    stb.memWrite = s3Valid && wrIsWrite;
    stb.push     = s3Valid;
    stb.pop      = rspValid && rspReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s3Valid <= 1'b0;
    end else begin
      s1Valid <= stb.capture;
      s2Valid <= s1Valid;
      s3Valid <= s2Valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCount  <= '0;
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (stb.push)
        tailPtr <= (tailPtr == PTR_W'(QDEPTH - 1)) ? '0 : tailPtr + 1'b1;
      if (stb.pop)
        headPtr <= (headPtr == PTR_W'(QDEPTH - 1)) ? '0 : headPtr + 1'b1;
      case ({stb.push, stb.pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // queue never receives a response it has no slot for (R8)
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !stb.pop) |-> (qCount < CNT_W'(QDEPTH)));

  // a waiting response is not withdrawn (R8)
  assert_rsp_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // accepted request reaches the queue three edges later (R7)
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> ##2 stb.push);

endmodule

// File: rtl/natomic_datapath.sv
module natomic_datapath
  import natomic_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int QDEPTH = 8,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [1:0]        reqOp,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  output logic              wrIsWrite,
  output logic              matchS1Ex,
  output logic              matchS1Wr,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData
);

  // read stage
  atomOp_e           s1Op;
  logic [ID_W-1:0]   s1Id;
  logic [ADDR_W-1:0] s1Addr;
  logic [DATA_W-1:0] s1Data;
  // compute stage
  atomOp_e           s2Op;
  logic [ID_W-1:0]   s2Id;
  logic [ADDR_W-1:0] s2Addr;
  logic [DATA_W-1:0] s2Data;
  logic [DATA_W-1:0] s2Old;
  logic [DATA_W-1:0] s2New;
  // write stage
  atomOp_e           s3Op;
  logic [ID_W-1:0]   s3Id;
  logic [ADDR_W-1:0] s3Addr;
  logic [DATA_W-1:0] s3Old;
  logic [DATA_W-1:0] s3New;

  logic [DATA_W-1:0] arrayWord;
  logic [DATA_W-1:0] oldSel;

  logic [ID_W-1:0]   qId   [QDEPTH];
  logic [DATA_W-1:0] qData [QDEPTH];

  natomic_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (stb.memWrite),
    .wrAddr (s3Addr),
    .wrData (s3New),
    .rdAddr (s1Addr),
    .rdData (arrayWord)
  );

  assign matchS1Ex = (s1Addr == s2Addr);
  assign matchS1Wr = (s1Addr == s3Addr);
  assign wrIsWrite = (s3Op == OP_ADD) || (s3Op == OP_XCHG);

  // youngest older result wins
  always_comb begin
    if (stb.fwdEx)      oldSel = s2New;
    else if (stb.fwdWr) oldSel = s3New;
    else                oldSel = arrayWord;
  end

  always_comb begin
    case (s2Op)
      OP_ADD:  s2New = s2Old + s2Data;
      OP_XCHG: s2New = s2Data;
      default: s2New = s2Old;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Op <= OP_READ; s1Id <= '0; s1Addr <= '0; s1Data <= '0;
      s2Op <= OP_READ; s2Id <= '0; s2Addr <= '0; s2Data <= '0; s2Old <= '0;
      s3Op <= OP_READ; s3Id <= '0; s3Addr <= '0; s3Old <= '0; s3New <= '0;
    end else begin
      if (stb.capture) begin
        s1Op   <= atomOp_e'(reqOp);
        s1Id   <= reqId;
        s1Addr <= reqAddr;
        s1Data <= reqData;
      end
      if (stb.adv2) begin
        s2Op   <= s1Op;
        s2Id   <= s1Id;
        s2Addr <= s1Addr;
        s2Data <= s1Data;
        s2Old  <= oldSel;
      end
      if (stb.adv3) begin
        s3Op   <= s2Op;
        s3Id   <= s2Id;
        s3Addr <= s2Addr;
        s3Old  <= s2Old;
        s3New  <= s2New;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) begin
      qId[tailPtr]   <= s3Id;
      qData[tailPtr] <= s3Old;
    end
  end

  assign rspId   = qId[headPtr];
  assign rspData = qData[headPtr];

  // read-only opcodes leave the stored word untouched (R4)
  assert_read_no_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !wrIsWrite) |-> (s3New == s3Old));

  // exchange commits exactly the operand it carried (R3)
  assert_xchg_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.adv3 && s2Op == OP_XCHG) |=> (s3New == $past(s2Data)));

endmodule

// File: rtl/near_atomic_alu.sv
module near_atomic_alu
  import natomic_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int QDEPTH = 8,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData
);

  strobes_t         stb;
  logic             wrIsWrite, matchS1Ex, matchS1Wr;
  logic [PTR_W-1:0] headPtr, tailPtr;

  natomic_ctrl #(.QDEPTH(QDEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .rspReady  (rspReady),
    .rspValid  (rspValid),
    .wrIsWrite (wrIsWrite),
    .matchS1Ex (matchS1Ex),
    .matchS1Wr (matchS1Wr),
    .stb       (stb),
    .headPtr   (headPtr),
    .tailPtr   (tailPtr)
  );

  natomic_datapath #(
    .WORDS(WORDS), .DATA_W(DATA_W), .ID_W(ID_W), .QDEPTH(QDEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqOp     (reqOp),
    .reqId     (reqId),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .headPtr   (headPtr),
    .tailPtr   (tailPtr),
    .wrIsWrite (wrIsWrite),
    .matchS1Ex (matchS1Ex),
    .matchS1Wr (matchS1Wr),
    .rspId     (rspId),
    .rspData   (rspData)
  );

  // a stalled response keeps its tag and value (R5, R8)
  assert_rsp_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspId) && $stable(rspData)));

endmodule

// File: tb/near_atomic_alu_tb.sv
module near_atomic_alu_tb;

  localparam int WORDS = 16;
  localparam int ID_W  = 4;
  localparam int QD    = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = '0;
  logic [3:0]  reqId = '0;
  logic [3:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [3:0]  rspId;
  logic [31:0] rspData;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit holdOff = 1'b1;
  bit finished = 1'b0;

  logic [31:0] model [WORDS];
  logic [3:0]  expId [$];
  logic [31:0] expData [$];
  string       expTag [$];

  always #2 clk = ~clk;  // 250 MHz

  near_atomic_alu #(.WORDS(WORDS), .DATA_W(32), .ID_W(ID_W), .QDEPTH(QD)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqId(reqId), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspId(rspId), .rspData(rspData)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] applyOp(input logic [1:0] op, input logic [31:0] old,
                                          input logic [31:0] d);
    case (op)
      2'd0:    return old + d;   // R2, R9 wrap
      2'd1:    return d;         // R3
      default: return old;       // R4
    endcase
  endfunction

  // expected response is recorded at the cycle the request is accepted
  task automatic record(input logic [1:0] op, input logic [3:0] id, input logic [3:0] a,
                        input logic [31:0] d, input string tag);
    expId.push_back(id);
    expData.push_back(model[a]);
    expTag.push_back(tag);
    model[a] = applyOp(op, model[a], d);
  endtask

  task automatic sendReq(input logic [1:0] op, input logic [3:0] id, input logic [3:0] a,
                         input logic [31:0] d, input string tag);
    reqValid = 1'b1; reqOp = op; reqId = id; reqAddr = a; reqData = d;
    while (!reqReady) @(negedge clk);
    record(op, id, a, d, tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expId.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  // response consumer: pick ready, and if a handshake will occur at the next edge, check it
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit r;
      r = holdOff ? 1'b0 : (($urandom % 4) != 0);
      rspReady = r;
      if (rspValid && r) begin
        if (expId.size() == 0) begin
          check("R5 unexpected response", 64'(rspId), 64'hFFFF);
        end else begin
          // R5 tag echo and order
          check({expTag[0], " R5 id"}, 64'(rspId), 64'(expId[0]));
          check({expTag[0], " data"}, 64'(rspData), 64'(expData[0]));
          void'(expId.pop_front());
          void'(expData.pop_front());
          expTag.delete(0);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  heldId;
    logic [31:0] heldData;
    void'($urandom(32'd4242));
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 rspValid", 64'(rspValid), 64'd0);
    check("R1 reqReady", 64'(reqReady), 64'd1);

    // R7 latency: accepted at edge N, valid after edge N+3
    reqValid = 1'b1; reqOp = 2'd2; reqId = 4'h9; reqAddr = 4'd7; reqData = '0;
    record(2'd2, 4'h9, 4'd7, 32'd0, "R7");
    @(negedge clk); reqValid = 1'b0;
    check("R7 valid after 1 edge", 64'(rspValid), 64'd0);
    @(negedge clk);
    check("R7 valid after 2 edges", 64'(rspValid), 64'd0);
    @(negedge clk);
    check("R7 valid after 3 edges", 64'(rspValid), 64'd0);
    @(negedge clk);
    check("R7 valid after edge N+3", 64'(rspValid), 64'd1);
    holdOff = 1'b0;
    drain();

    // R1 every word reads zero after reset (read opcode 2)
    for (int a = 0; a < WORDS; a++) sendReq(2'd2, 4'(a), 4'(a), 32'hDEAD_BEEF, "R1 word");
    drain();

    // R9 wrap and R2 fetch-add, R3 exchange, R4 opcode 3 as read
    sendReq(2'd1, 4'h1, 4'd5, 32'hFFFF_FFF0, "R3 xchg");
    sendReq(2'd0, 4'h2, 4'd5, 32'h0000_0020, "R9 wrap add");
    sendReq(2'd3, 4'h3, 4'd5, 32'h1234_5678, "R4 op3 read");
    sendReq(2'd2, 4'h4, 4'd5, 32'h0, "R4 read after wrap");
    drain();

    // R6 back-to-back fetch-adds to one word, then exchange/read chain
    for (int k = 0; k < 6; k++) sendReq(2'd0, 4'(k), 4'd2, 32'(k + 1), "R6 burst add");
    sendReq(2'd1, 4'hA, 4'd2, 32'h5555_0000, "R6 xchg in burst");
    sendReq(2'd0, 4'hB, 4'd2, 32'h1, "R6 add after xchg");
    sendReq(2'd2, 4'hC, 4'd2, 32'h0, "R6 read tail");
    drain();

    // R8 back-pressure: queue fills, ready drops, head holds
    holdOff = 1'b1;
    for (int k = 0; k < QD; k++) sendReq(2'd0, 4'(k), 4'd9, 32'd3, "R8 fill");
    check("R8 ready low when full", 64'(reqReady), 64'd0);
    repeat (3) @(negedge clk);
    heldId = rspId; heldData = rspData;
    repeat (4) @(negedge clk);
    check("R8 rspValid held", 64'(rspValid), 64'd1);
    check("R8 rspId held", 64'(rspId), 64'(heldId));
    check("R8 rspData held", 64'(rspData), 64'(heldData));
    check("R8 ready still low", 64'(reqReady), 64'd0);
    holdOff = 1'b0;
    drain();

    // random mix: R2 R3 R4 R5 R6 R9, mostly a narrow address window
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = (($urandom % 5) != 0) ? 4'($urandom % 4) : 4'($urandom);
      d = (($urandom % 4) == 0) ? (32'hFFFF_FF00 | 32'($urandom % 256)) : $urandom;
      sendReq(2'($urandom), 4'($urandom), a, d, "R5 random");
    end
    drain();
    check("R5 all responses returned", 64'(expId.size()), 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule